// File: doc/BRIEF.md
# Wait-for-Interrupt / Wait-for-Event Sleep Controller

This block parks processor cores that execute one of two wait instructions and brings them back when something worth waking for happens. Each core has its own lane. A wait-for-interrupt request puts the lane to sleep until an interrupt, a debug request or a reset request arrives. A wait-for-event request also ends on any event. The events are a send-event broadcast to all cores, a send-event local to that core, a periodic timer tick, and an exclusive-monitor clear pulse for that core.

Every lane holds a one-bit sticky event flag. Any event sets it, whether the core is awake or sleeping in wait-for-interrupt. A wait-for-event request that finds the flag set, or that sees an event in the same cycle, clears the flag and does not sleep. This means a release that comes just before the waiter reaches its sleep is never lost.

While a lane sleeps, its clock enable is held low so the core's pipeline stops toggling. When a lane wakes, the clock enable rises first. One cycle later the lane sends a single-cycle wake acknowledge to the core.

Top module: `wait_sleep_ctrl`

## Requirements
- R1: A lane sleeping on wait-for-interrupt wakes only when its `irq`, `dbg_req` or `core_rst_req` bit is high. Events sampled during this sleep do not wake it.
- R2: A lane sleeping on wait-for-event wakes on any R1 source, and also on `sev_bcast`, on `timer_tick`, on its own `sev_local` bit or on its own `mon_clr` bit.
- R3: A lane's event flag is set by any event source that reaches it. The flag stays set until a wait-for-event consumes it.
- R4: A wait-for-event request accepted while the flag is set, or while an event reaches the lane in the same cycle, does not sleep: `clk_en` stays 1 and `asleep` stays 0. The flag is cleared, so the next wait-for-event request sleeps.
- R5: `sev_bcast` sets the event flag of every lane. Bit i of `sev_local` sets only the flag of lane i.
- R6: Starting the cycle after a wait request is accepted, and until the lane wakes, `clk_en` is 0 and `asleep` is 1.
- R7: In the cycle after a wake condition is sampled, `clk_en` is 1 and `asleep` is 0. In the next cycle `wake_ack` is 1 for exactly one cycle.
- R8: A lane that wakes from wait-for-event leaves its event flag cleared.
- R9: A synchronous `rst` makes every lane awake: `clk_en`=1, `asleep`=0 and `wake_ack`=0. It also clears every event flag.
- R10: If `wfi_req` and `wfe_req` are both high in the same cycle, the lane sleeps on wait-for-interrupt and does not consume its event flag.
- R11: Wait requests are accepted only while the lane is fully awake. A request sampled in the wake cycle or in the acknowledge cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | NUM_CORES | Wait-for-interrupt request, one bit per core |
| wfe_req | input | NUM_CORES | Wait-for-event request, one bit per core |
| sev_local | input | NUM_CORES | Local send-event, one bit per core |
| sev_bcast | input | 1 | Send-event broadcast to all cores |
| timer_tick | input | 1 | Periodic timer event pulse to all cores |
| mon_clr | input | NUM_CORES | Exclusive-monitor clear pulse, one bit per core |
| irq | input | NUM_CORES | Interrupt line, one bit per core |
| dbg_req | input | NUM_CORES | Debug request, one bit per core |
| core_rst_req | input | NUM_CORES | Core reset request (wake source), one bit per core |
| clk_en | output | NUM_CORES | Pipeline clock enable per core, low while asleep |
| asleep | output | NUM_CORES | Core is parked in a wait state |
| wake_ack | output | NUM_CORES | Single-cycle pulse one cycle after clock enable returns |

## Verification
The assertions check the per-cycle rules on every cycle:
- A wait-for-interrupt sleep holds through events.
- Any event ends a wait-for-event sleep.
- The flag is sticky, and a wait-for-event sleep never holds a set flag.
- A pending flag blocks sleep.
- Wait-for-interrupt has priority when both requests arrive together.
- The acknowledge follows the clock enable.

Other behaviours appear only in the bench scenarios. These are the cross-lane reach of broadcast versus local send-event, and the fact that a reset or a consumed flag changes whether a later wait-for-event request sleeps. Both show up only over several requests observed at the ports.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_SLP_WFI = 3'd1,
        ST_SLP_WFE = 3'd2,
        ST_RESUME  = 3'd3,
        ST_ACK     = 3'd4
    } wsc_state_e;

    typedef struct packed {
        logic irq;
        logic dbg;
        logic rst_req;
    } wake_src_t;

    typedef struct packed {
        logic bcast;
        logic local_sev;
        logic tick;
        logic mon_clr;
    } event_src_t;

    function automatic logic any_wake(wake_src_t w);
        return w.irq | w.dbg | w.rst_req;
    endfunction

    function automatic logic any_event(event_src_t e);
        return e.bcast | e.local_sev | e.tick | e.mon_clr;
    endfunction

    function automatic logic is_sleeping(wsc_state_e s);
        return (s == ST_SLP_WFI) || (s == ST_SLP_WFE);
    endfunction

endpackage

// File: rtl/wsc_event_reg.sv
module wsc_event_reg (
    input  logic clk,
    input  logic rst,
    input  logic ev_set,
    input  logic consume,
    output logic ev_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ev_q <= 1'b0;
        else if (consume)
            ev_q <= 1'b0;
        else if (ev_set)
            ev_q <= 1'b1;
    end

    AST_EV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ev_q && !consume) |=> ev_q);                       // R3
    AST_EV_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ev_set && !consume) |=> ev_q);                     // R3
    AST_EV_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        consume |=> !ev_q);                                 // R4

endmodule

// File: rtl/wsc_core_fsm.sv
module wsc_core_fsm
    import wsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wfi_req,
    input  logic      wfe_req,
    input  wake_src_t wake_src,
    input  logic      ev_in,
    input  logic      ev_q,
    output logic      consume,
    output logic      clk_en,
    output logic      asleep,
    output logic      wake_ack
);

    wsc_state_e state_q, state_d;
    logic wake_i, wake_e, pending;

    assign wake_i  = any_wake(wake_src);
    assign wake_e  = wake_i | ev_in;
    assign pending = ev_q | ev_in;

    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                if (wfi_req) begin
                    state_d = ST_SLP_WFI;
                end else if (wfe_req) begin
                    if (pending)
                        consume = 1'b1;
                    else
                        state_d = ST_SLP_WFE;
                end
            end
            ST_SLP_WFI: begin
                if (wake_i)
                    state_d = ST_RESUME;
            end
            ST_SLP_WFE: begin
                if (wake_e) begin
                    state_d = ST_RESUME;
                    consume = 1'b1;
                end
            end
            ST_RESUME: state_d = ST_ACK;
            ST_ACK:    state_d = ST_AWAKE;
            default:   state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_AWAKE;
        else
            state_q <= state_d;
    end

    assign asleep   = is_sleeping(state_q);
    assign clk_en   = !is_sleeping(state_q);
    assign wake_ack = (state_q == ST_ACK);

    AST_WFI_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLP_WFI && !wake_i) |=> (state_q == ST_SLP_WFI));   // R1
    AST_WFE_EVENT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLP_WFE && ev_in) |=> (state_q == ST_RESUME));      // R2
    AST_PENDING_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_AWAKE && wfe_req && !wfi_req && pending)
        |=> (state_q == ST_AWAKE));                                        // R4
    AST_WFE_FLAG_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLP_WFE) |-> !ev_q);                                // R8
    AST_WFI_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_AWAKE && wfi_req) |=> (state_q == ST_SLP_WFI));     // R10
    AST_RESUME_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME) |=> (state_q == ST_ACK));                   // R11

endmodule

// File: rtl/wsc_core_slice.sv
module wsc_core_slice
    import wsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic sev_local,
    input  logic sev_bcast,
    input  logic timer_tick,
    input  logic mon_clr,
    input  logic irq,
    input  logic dbg_req,
    input  logic core_rst_req,
    output logic clk_en,
    output logic asleep,
    output logic wake_ack
);

    event_src_t evs;
    wake_src_t  wks;
    logic       ev_in, ev_q, consume;

    assign evs = '{bcast: sev_bcast, local_sev: sev_local,
                   tick: timer_tick, mon_clr: mon_clr};
    assign wks = '{irq: irq, dbg: dbg_req, rst_req: core_rst_req};
    assign ev_in = any_event(evs);

    wsc_event_reg u_evreg (
        .clk     (clk),
        .rst     (rst),
        .ev_set  (ev_in),
        .consume (consume),
        .ev_q    (ev_q)
    );

    wsc_core_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wfi_req  (wfi_req),
        .wfe_req  (wfe_req),
        .wake_src (wks),
        .ev_in    (ev_in),
        .ev_q     (ev_q),
        .consume  (consume),
        .clk_en   (clk_en),
        .asleep   (asleep),
        .wake_ack (wake_ack)
    );

    AST_ACK_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        wake_ack |-> ($past(clk_en) && !$past(wake_ack)));   // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_ack |=> !wake_ack);                             // R7
    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> !clk_en);                          // R6

endmodule

// File: rtl/wait_sleep_ctrl.sv
module wait_sleep_ctrl
    import wsc_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] wfi_req,
    input  logic [NUM_CORES-1:0] wfe_req,
    input  logic [NUM_CORES-1:0] sev_local,
    input  logic                 sev_bcast,
    input  logic                 timer_tick,
    input  logic [NUM_CORES-1:0] mon_clr,
    input  logic [NUM_CORES-1:0] irq,
    input  logic [NUM_CORES-1:0] dbg_req,
    input  logic [NUM_CORES-1:0] core_rst_req,
    output logic [NUM_CORES-1:0] clk_en,
    output logic [NUM_CORES-1:0] asleep,
    output logic [NUM_CORES-1:0] wake_ack
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        wsc_core_slice u_slice (
            .clk          (clk),
            .rst          (rst),
            .wfi_req      (wfi_req[c]),
            .wfe_req      (wfe_req[c]),
            .sev_local    (sev_local[c]),
            .sev_bcast    (sev_bcast),
            .timer_tick   (timer_tick),
            .mon_clr      (mon_clr[c]),
            .irq          (irq[c]),
            .dbg_req      (dbg_req[c]),
            .core_rst_req (core_rst_req[c]),
            .clk_en       (clk_en[c]),
            .asleep       (asleep[c]),
            .wake_ack     (wake_ack[c])
        );
    end

    AST_RESET_AWAKE: assert property (@(posedge clk)
        rst |=> ((&clk_en) && !(|asleep) && !(|wake_ack)));   // R9

endmodule

// File: tb/wait_sleep_ctrl_bench.sv
module wait_sleep_ctrl_bench;

    localparam int N  = 4;
    localparam int NV = 38;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] wfi_req, wfe_req, sev_local, mon_clr, irq, dbg_req, core_rst_req;
    logic sev_bcast, timer_tick;
    logic [N-1:0] clk_en, asleep, wake_ack;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wait_sleep_ctrl #(.NUM_CORES(N)) u_wait_sleep_ctrl (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .sev_local(sev_local), .sev_bcast(sev_bcast), .timer_tick(timer_tick),
        .mon_clr(mon_clr), .irq(irq), .dbg_req(dbg_req),
        .core_rst_req(core_rst_req), .clk_en(clk_en), .asleep(asleep),
        .wake_ack(wake_ack)
    );

    // Row: {wfi, wfe, sevl, bcast, tick, mon, irq, dbg, crst, en, slp, ack} for core 0
    localparam logic [11:0] VEC [NV] = '{
        12'b000000000_100, // R9 idle after reset
        12'b100000000_010, // R6 wfi sleeps
        12'b000100000_010, // R1 broadcast ignored in wfi
        12'b000010000_010, // R1 tick ignored
        12'b000001000_010, // R1 monitor clear ignored
        12'b000000000_010, // R6 still asleep
        12'b000000100_100, // R1 irq wakes, R7 enable first
        12'b000000000_101, // R7 ack pulse
        12'b000000000_100, // R7 ack ends
        12'b010000000_100, // R3 flag held from wfi sleep, R4 no sleep
        12'b010000000_010, // R4 flag consumed, sleeps
        12'b000000000_010, // R6
        12'b000010000_100, // R2 tick wakes wfe
        12'b000000000_101, // R7
        12'b000000000_100, // R7
        12'b010000000_010, // R8 flag cleared on wake
        12'b000001000_100, // R2 monitor clear wakes
        12'b000000000_101, // R7
        12'b000000000_100, // R7
        12'b011000000_100, // R4 same-cycle event blocks sleep
        12'b010000000_010, // R4 then sleeps
        12'b001000000_100, // R2 local send-event wakes
        12'b000000000_101, // R7
        12'b000000000_100, // R7
        12'b010000000_010, // R8
        12'b000000010_100, // R2 debug wakes wfe
        12'b100000000_101, // R11 request during resume ignored
        12'b000000000_100, // R11 stays awake
        12'b110000000_010, // R10 both requests: wfi wins
        12'b000010000_010, // R10 tick does not wake (wfi sleep)
        12'b000000001_100, // R1 reset request wakes
        12'b000000000_101, // R7
        12'b000000000_100, // R7
        12'b010000000_100, // R3 tick during wfi kept flag
        12'b010000000_010, // R4
        12'b000000100_100, // R2 irq wakes wfe
        12'b010000000_101, // R11 request during resume ignored
        12'b000000000_100  // R11
    };

    task automatic clear_inputs();
        wfi_req = '0; wfe_req = '0; sev_local = '0; mon_clr = '0;
        irq = '0; dbg_req = '0; core_rst_req = '0;
        sev_bcast = 1'b0; timer_tick = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clk_en", clk_en, '1);
        chk("R9 reset asleep", asleep, '0);

        for (int k = 0; k < NV; k++) begin
            clear_inputs();
            wfi_req[0]      = VEC[k][11];
            wfe_req[0]      = VEC[k][10];
            sev_local[0]    = VEC[k][9];
            sev_bcast       = VEC[k][8];
            timer_tick      = VEC[k][7];
            mon_clr[0]      = VEC[k][6];
            irq[0]          = VEC[k][5];
            dbg_req[0]      = VEC[k][4];
            core_rst_req[0] = VEC[k][3];
            step();
            n_chk++;
            if ({clk_en[0], asleep[0], wake_ack[0]} !== VEC[k][2:0]) begin
                n_fail++;
                $display("FAIL vector %0d (see row tag) actual=%b expected=%b",
                         k, {clk_en[0], asleep[0], wake_ack[0]}, VEC[k][2:0]);
            end
        end

        // R9: reset clears outputs and all flags (flags were set by broadcast/tick)
        clear_inputs();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9 clk_en after reset", clk_en, '1);
        chk("R9 ack after reset", wake_ack, '0);
        wfe_req[1] = 1'b1;
        step();
        clear_inputs();
        chk("R9 flag cleared, core1 wfe sleeps", asleep, 4'b0010);

        // R5: local send-event on core 0 does not reach core 1
        sev_local[0] = 1'b1;
        step();
        clear_inputs();
        chk("R5 local reaches only own lane", asleep, 4'b0010);
        wfe_req[0] = 1'b1;
        step();
        clear_inputs();
        chk("R5 own flag set, core0 no sleep", asleep, 4'b0010);

        wfe_req[2] = 1'b1; wfe_req[3] = 1'b1;
        step();
        clear_inputs();
        chk("R6 cores 1-3 asleep", asleep, 4'b1110);
        chk("R6 cores 1-3 gated", clk_en, 4'b0001);
        sev_bcast = 1'b1;
        step();
        clear_inputs();
        chk("R5 broadcast wakes all", clk_en, 4'b1111);
        step();
        chk("R7 ack on all woken lanes", wake_ack, 4'b1110);
        step();

        // R2: monitor clear reaches only its own lane
        wfe_req[2] = 1'b1; wfe_req[3] = 1'b1;
        step();
        clear_inputs();
        mon_clr[3] = 1'b1;
        step();
        clear_inputs();
        chk("R2 monitor clear wakes only lane 3", asleep, 4'b0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule